// File: doc/BRIEF.md
# GPI Event Routing Controller

This block decides, for each of up to sixteen general-purpose input pins, what a latched status event on that pin should raise. A 32-bit read/write routing register holds one 2-bit field per pin. The field picks the system-management interrupt (SMI), the system-control interrupt (SCI), or no interrupt. A routed event fires only when three things hold: the pin's status bit is set, its GPE1 enable bit is set, and the pin is configured as an input.

While the system sits in a sleep state (S1 to S5), an enabled status event on an implemented pin also raises a wake request. This happens whatever the route field holds. The three outputs are level signals: each is the OR of the per-pin terms, captured in a flop one cycle after the inputs.

The set of implemented pins is fixed by a parameter mask. Fields of absent pins have no storage, read as zero and ignore writes. The routing register keeps its value through a core reset and is cleared only by the separate resume-well reset. The core reset clears the three output flops.

Top module: `gpi_event_router`

## Requirements
- R1: Asserting rst_resume_n clears every routing field to 0, and while either reset is asserted smi_o, sci_o and wake_o are 0.
- R2: A cycle with cfg_wr set stores cfg_wdata into the fields of implemented pins; cfg_rdata shows the new value after that clock edge, and the register is unchanged in cycles without cfg_wr.
- R3: The field of pin n sits at bits [2n+1:2n]. For a pin whose bit in IMPL_MASK is 0, the field reads 0 and ignores writes, and that pin never raises SMI, SCI or wake (default mask 16'h39DB: pins 0,1,3,4,6,7,8,11,12,13).
- R4: Route 2'b01 on pin n, with pin_sts[n], pin_is_input[n] and gpe1_en[n] all 1, sets smi_o at the clock edge after those inputs are present.
- R5: Route 2'b10 under the same conditions sets sci_o at the following clock edge.
- R6: Routes 2'b00 and 2'b11 raise neither SMI nor SCI.
- R7: A pin with pin_is_input[n] = 0 (output) raises neither SMI nor SCI, whatever its route.
- R8: A pin whose status bit or GPE1 enable bit is 0 raises no SMI, SCI or wake.
- R9: With sleep_state in 1..5, an implemented pin with status and GPE1 enable set drives wake_o at the next edge for any route value; sleep_state 0, 6 or 7 gives no wake.
- R10: Asserting rst_core_n leaves the routing register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_resume_n | input | 1 | Resume-well reset, active low, clears the routing register |
| rst_core_n | input | 1 | Core reset, active low, clears only the output flops |
| cfg_wr | input | 1 | Write strobe for the routing register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current routing register contents |
| pin_sts | input | 16 | Latched status bit per pin |
| pin_is_input | input | 16 | 1 when the pin is configured as an input |
| gpe1_en | input | 16 | GPE1 enable per pin |
| sleep_state | input | 3 | Current sleep state: 0 working, 1..5 S1..S5, 6..7 unused |
| smi_o | output | 1 | Registered SMI request level |
| sci_o | output | 1 | Registered SCI request level |
| wake_o | output | 1 | Registered wake request level |

## Verification
Each reset pin is released through a two-flop synchronizer. The assertions therefore assume that no write is issued during the two cycles after rst_resume_n rises. The write-effect property would otherwise see a write dropped while the internal reset is still held. The bench waits several cycles after every reset release before it drives cfg_wr. Random status, direction, enable and sleep values are otherwise unconstrained, so any combination of inputs is legal for the interrupt and wake properties.

// File: rtl/gpi_route_pkg.sv
package gpi_route_pkg;

  localparam int unsigned FIELD_W = 2;
  localparam int unsigned SLP_W   = 3;

  typedef enum logic [FIELD_W-1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_SMI  = 2'b01,
    ROUTE_SCI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  typedef struct packed {
    logic smi;
    logic sci;
    logic wake;
  } evt_t;

  function automatic logic state_is_asleep(input logic [SLP_W-1:0] st);
    return (st >= 3'd1) && (st <= 3'd5);
  endfunction

endpackage

// File: rtl/gpi_rst_sync.sv
module gpi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/gpi_route_reg.sv
module gpi_route_reg #(
  parameter int unsigned NUM_PINS  = 16,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = 16'h39DB,
  localparam int unsigned REG_W    = NUM_PINS * gpi_route_pkg::FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] route_q
);
  import gpi_route_pkg::*;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_field
    if (IMPL_MASK[g]) begin : g_impl
      logic [FIELD_W-1:0] fld_q;
      logic [FIELD_W-1:0] fld_nxt;

      always_comb begin
        fld_nxt = fld_q;
        if (wr_en) begin
          fld_nxt = wdata[g*FIELD_W +: FIELD_W];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fld_q <= '0;
        end else begin
          fld_q <= fld_nxt;
        end
      end

      assign route_q[g*FIELD_W +: FIELD_W] = fld_q;
    end else begin : g_absent
      assign route_q[g*FIELD_W +: FIELD_W] = '0;
    end
  end

endmodule

// File: rtl/gpi_pin_decode.sv
module gpi_pin_decode (
  input  logic                                  clk_unused,
  input  logic [gpi_route_pkg::FIELD_W-1:0]     route,
  input  logic                                  sts,
  input  logic                                  is_input,
  input  logic                                  en,
  input  logic                                  asleep,
  output gpi_route_pkg::evt_t                   evt
);
  import gpi_route_pkg::*;

  logic armed;
  logic unused_clk;

  assign unused_clk = clk_unused;
  assign armed      = sts & en;

  always_comb begin
    evt      = '0;
    evt.wake = armed & asleep;
    if (armed && is_input) begin
      case (route_e'(route))
        ROUTE_SMI: evt.smi = 1'b1;
        ROUTE_SCI: evt.sci = 1'b1;
        default:   evt     = evt;
      endcase
    end
  end

endmodule

// File: rtl/gpi_event_router.sv
module gpi_event_router #(
  parameter int unsigned NUM_PINS  = 16,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = 16'h39DB,
  localparam int unsigned REG_W    = NUM_PINS * gpi_route_pkg::FIELD_W
) (
  input  logic                               clk,
  input  logic                               rst_resume_n,
  input  logic                               rst_core_n,
  input  logic                               cfg_wr,
  input  logic [REG_W-1:0]                   cfg_wdata,
  output logic [REG_W-1:0]                   cfg_rdata,
  input  logic [NUM_PINS-1:0]                pin_sts,
  input  logic [NUM_PINS-1:0]                pin_is_input,
  input  logic [NUM_PINS-1:0]                gpe1_en,
  input  logic [gpi_route_pkg::SLP_W-1:0]    sleep_state,
  output logic                               smi_o,
  output logic                               sci_o,
  output logic                               wake_o
);
  import gpi_route_pkg::*;

  logic               resume_srst_n;
  logic               core_srst_n;
  logic [REG_W-1:0]   route_q;
  logic               asleep;
  evt_t               pin_evt [NUM_PINS];
  evt_t               any_evt;
  evt_t               out_q;
  evt_t               out_nxt;

  gpi_rst_sync u_rst_resume (
    .clk    (clk),
    .arst_n (rst_resume_n),
    .srst_n (resume_srst_n)
  );

  gpi_rst_sync u_rst_core (
    .clk    (clk),
    .arst_n (rst_core_n),
    .srst_n (core_srst_n)
  );

  gpi_route_reg #(
    .NUM_PINS  (NUM_PINS),
    .IMPL_MASK (IMPL_MASK)
  ) u_reg (
    .clk     (clk),
    .rst_n   (resume_srst_n),
    .wr_en   (cfg_wr),
    .wdata   (cfg_wdata),
    .route_q (route_q)
  );

  assign cfg_rdata = route_q;
  assign asleep    = state_is_asleep(sleep_state);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    if (IMPL_MASK[g]) begin : g_impl
      gpi_pin_decode u_dec (
        .clk_unused (clk),
        .route      (route_q[g*FIELD_W +: FIELD_W]),
        .sts        (pin_sts[g]),
        .is_input   (pin_is_input[g]),
        .en         (gpe1_en[g]),
        .asleep     (asleep),
        .evt        (pin_evt[g])
      );
    end else begin : g_absent
      assign pin_evt[g] = '0;
    end
  end

  always_comb begin
    any_evt = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      any_evt = any_evt | pin_evt[i];
    end
  end

  always_comb begin
    out_nxt = any_evt;
  end

  always_ff @(posedge clk or negedge core_srst_n) begin
    if (!core_srst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_nxt;
    end
  end

  assign smi_o  = out_q.smi  & rst_resume_n & rst_core_n;
  assign sci_o  = out_q.sci  & rst_resume_n & rst_core_n;
  assign wake_o = out_q.wake & rst_resume_n & rst_core_n;

endmodule

// File: rtl/gpi_event_router_chk.sv
module gpi_event_router_chk #(
  parameter int unsigned NUM_PINS  = 16,
  parameter logic [NUM_PINS-1:0] IMPL_MASK = 16'h39DB,
  localparam int unsigned REG_W    = NUM_PINS * 2
) (
  input logic                clk,
  input logic                rst_resume_n,
  input logic                rst_core_n,
  input logic                cfg_wr,
  input logic [REG_W-1:0]    cfg_wdata,
  input logic [REG_W-1:0]    cfg_rdata,
  input logic [NUM_PINS-1:0] pin_sts,
  input logic [NUM_PINS-1:0] pin_is_input,
  input logic [NUM_PINS-1:0] gpe1_en,
  input logic [2:0]          sleep_state,
  input logic                smi_o,
  input logic                sci_o,
  input logic                wake_o
);

  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (IMPL_MASK[i]) m[2*i +: 2] = 2'b11;
    end
    return m;
  endfunction

  function automatic logic routed_hit(input logic [REG_W-1:0] r,
                                      input logic [NUM_PINS-1:0] s,
                                      input logic [NUM_PINS-1:0] d,
                                      input logic [NUM_PINS-1:0] e,
                                      input logic [1:0] code);
    logic h;
    h = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (r[2*i +: 2] == code && s[i] && d[i] && e[i]) h = 1'b1;
    end
    return h;
  endfunction

  localparam logic [REG_W-1:0] FMASK = field_mask();

  // R3
  absent_fields_zero_chk: assert property (@(posedge clk)
    disable iff (!rst_resume_n)
    (cfg_rdata & ~FMASK) == '0);

  // R2
  write_lands_chk: assert property (@(posedge clk)
    disable iff (!rst_resume_n)
    cfg_wr |=> cfg_rdata == ($past(cfg_wdata) & FMASK));

  // R2 R10
  hold_no_write_chk: assert property (@(posedge clk)
    disable iff (!rst_resume_n)
    !cfg_wr |=> $stable(cfg_rdata));

  // R4
  smi_cause_chk: assert property (@(posedge clk)
    disable iff (!rst_resume_n || !rst_core_n)
    smi_o |-> $past(routed_hit(cfg_rdata, pin_sts, pin_is_input, gpe1_en, 2'b01)));

  // R5
  sci_cause_chk: assert property (@(posedge clk)
    disable iff (!rst_resume_n || !rst_core_n)
    sci_o |-> $past(routed_hit(cfg_rdata, pin_sts, pin_is_input, gpe1_en, 2'b10)));

  // R9
  wake_cause_chk: assert property (@(posedge clk)
    disable iff (!rst_resume_n || !rst_core_n)
    wake_o |-> $past((sleep_state >= 3'd1) && (sleep_state <= 3'd5)
                     && ((pin_sts & gpe1_en & IMPL_MASK) != '0)));

  // R1
  always @(negedge clk) begin
    if (!rst_core_n || !rst_resume_n) begin
      outputs_quiet_in_reset_chk: assert (!smi_o && !sci_o && !wake_o);
    end
  end

endmodule

bind gpi_event_router gpi_event_router_chk #(
  .NUM_PINS  (NUM_PINS),
  .IMPL_MASK (IMPL_MASK)
) u_chk (.*);

// File: tb/sim_gpi_event_router.sv
`timescale 1ns/1ps
module sim_gpi_event_router;

  localparam int unsigned NP = 16;
  localparam logic [NP-1:0] MASK = 16'h39DB;

  logic        clk = 1'b0;
  logic        rst_resume_n, rst_core_n, cfg_wr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [15:0] pin_sts, pin_is_input, gpe1_en;
  logic [2:0]  sleep_state;
  logic        smi_o, sci_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] shadow;

  always #2 clk = ~clk;

  gpi_event_router u0 (
    .clk(clk), .rst_resume_n(rst_resume_n), .rst_core_n(rst_core_n),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pin_sts(pin_sts), .pin_is_input(pin_is_input), .gpe1_en(gpe1_en),
    .sleep_state(sleep_state), .smi_o(smi_o), .sci_o(sci_o), .wake_o(wake_o)
  );

  function automatic logic [31:0] fmask();
    logic [31:0] m = '0;
    for (int i = 0; i < NP; i++) if (MASK[i]) m[2*i +: 2] = 2'b11;
    return m;
  endfunction

  function automatic logic want_route(input logic [31:0] r, input logic [1:0] code);
    logic h = 1'b0;
    for (int i = 0; i < NP; i++)
      if (MASK[i] && r[2*i +: 2] == code && pin_sts[i] && pin_is_input[i] && gpe1_en[i]) h = 1'b1;
    return h;
  endfunction

  function automatic logic want_wake();
    return (sleep_state >= 3'd1 && sleep_state <= 3'd5) && ((pin_sts & gpe1_en & MASK) != '0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, cross one posedge, land on next negedge, compare.
  task automatic step(input logic wr, input logic [31:0] wd, input logic [15:0] s,
                      input logic [15:0] d, input logic [15:0] e, input logic [2:0] sl,
                      input string req);
    logic es, ec, ew;
    cfg_wr = wr; cfg_wdata = wd; pin_sts = s; pin_is_input = d; gpe1_en = e; sleep_state = sl;
    es = want_route(shadow, 2'b01);
    ec = want_route(shadow, 2'b10);
    ew = want_wake();
    @(negedge clk);
    cfg_wr = 1'b0;
    if (wr) shadow = wd & fmask();
    chk({req, " rdata"}, cfg_rdata, shadow);
    chk({req, " smi"},  {31'b0, smi_o},  {31'b0, es});
    chk({req, " sci"},  {31'b0, sci_o},  {31'b0, ec});
    chk({req, " wake"}, {31'b0, wake_o}, {31'b0, ew});
  endtask

  task automatic settle(input logic [31:0] wd, input logic [15:0] s, input logic [15:0] d,
                        input logic [15:0] e, input logic [2:0] sl, input string req);
    step(1'b1, wd, s, d, e, sl, {req, " setup"});
    step(1'b0, wd, s, d, e, sl, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_resume_n = 0; rst_core_n = 0; cfg_wr = 0; cfg_wdata = '0;
    pin_sts = '0; pin_is_input = '0; gpe1_en = '0; sleep_state = '0;
    shadow = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {29'b0, smi_o, sci_o, wake_o}, 32'd0);
    rst_resume_n = 1; rst_core_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset value", cfg_rdata, 32'd0);

    // R2 R3: all ones lands only in implemented fields
    step(1'b1, 32'hFFFF_FFFF, '0, '0, '0, 3'd0, "R2 R3 all-ones");
    chk("R3 absent fields", cfg_rdata & ~fmask(), 32'd0);
    step(1'b1, 32'h0000_0000, '0, '0, '0, 3'd0, "R2 clear");

    // R4: pin 0 to SMI
    settle(32'h0000_0001, 16'h0001, 16'h0001, 16'h0001, 3'd0, "R4 smi pin0");
    chk("R4 smi high", {31'b0, smi_o}, 32'd1);
    // R5: pin 1 to SCI
    settle(32'h0000_0008, 16'h0002, 16'h0002, 16'h0002, 3'd0, "R5 sci pin1");
    chk("R5 sci high", {31'b0, sci_o}, 32'd1);
    // R6: reserved code
    settle(32'h0000_0003, 16'h0001, 16'h0001, 16'h0001, 3'd0, "R6 reserved");
    chk("R6 no irq", {30'b0, smi_o, sci_o}, 32'd0);
    // R7: output pin
    settle(32'h0000_0001, 16'h0001, 16'h0000, 16'h0001, 3'd0, "R7 output pin");
    chk("R7 no smi", {31'b0, smi_o}, 32'd0);
    // R8: enable clear
    settle(32'h0000_0001, 16'h0001, 16'h0001, 16'h0000, 3'd3, "R8 enable off");
    chk("R8 nothing", {29'b0, smi_o, sci_o, wake_o}, 32'd0);
    // R9: wake with route none, then S0 and state 7
    settle(32'h0000_0000, 16'h0800, 16'h0000, 16'h0800, 3'd3, "R9 wake S3");
    chk("R9 wake high", {31'b0, wake_o}, 32'd1);
    step(1'b0, '0, 16'h0800, 16'h0000, 16'h0800, 3'd0, "R9 S0");
    step(1'b0, '0, 16'h0800, 16'h0000, 16'h0800, 3'd7, "R9 S7");
    chk("R9 no wake S7", {31'b0, wake_o}, 32'd0);
    // R3: absent pin 2 never wakes or routes
    settle(32'h0000_0010, 16'h0004, 16'h0004, 16'h0004, 3'd5, "R3 absent pin2");
    chk("R3 pin2 quiet", {29'b0, smi_o, sci_o, wake_o}, 32'd0);

    // R10: core reset keeps register
    settle(32'h0000_0001, 16'h0001, 16'h0001, 16'h0001, 3'd0, "R10 pre");
    rst_core_n = 0;
    @(negedge clk);
    chk("R10 smi low in core reset", {31'b0, smi_o}, 32'd0);
    chk("R10 register kept", cfg_rdata, 32'h0000_0001);
    rst_core_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 smi returns", {31'b0, smi_o}, 32'd1);

    // R1: resume reset clears
    rst_resume_n = 0;
    @(negedge clk);
    chk("R1 resume clears", cfg_rdata, 32'd0);
    shadow = '0;
    rst_resume_n = 1;
    repeat (4) @(negedge clk);

    // Random mix: R2 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 4) == 0, $urandom, 16'($urandom), 16'($urandom), 16'($urandom),
           3'($urandom), "R4 R5 R9 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule